// File: doc/BRIEF.md
# Data-Dependent Sign-Magnitude Multiplier

This unit multiplies two sign-magnitude operands and returns a sign-magnitude product. It is a computation stage for a self-timed filter datapath, modelled here as clocked logic. The magnitudes go through a carry-save partial-product array in which each row belongs to one bit of the multiplier magnitude. A row is switched on only when its bit is one. A row whose bit is zero passes its carry-save pair through untouched and costs no cycle. The time to a result therefore grows with the number of ones in the multiplier magnitude.

The multiplier magnitude arrives as dual-rail pairs. One rail carries "one" and the other carries "zero", and a pair with both rails low means the bit has not arrived yet. A four-phase return-to-zero handshake frames each operation. Raising `req` starts an evaluation, and `done` rises when the product is ready. Lowering `req` clears the stage, after which `done` falls. A pair with both rails high is a coding fault. It raises `err` and no evaluation starts.

Top module: `dd_smul`

## Requirements
- R1: When `done` rises, `p_mag` equals the product of the captured multiplicand magnitude and multiplier magnitude, 2*MAG_W bits wide (8 bits by default).
- R2: `p_sign` is the XOR of the two operand sign bits, except that a zero `p_mag` is always reported with `p_sign` = 0.
- R3: Multiplier bit n is coded on (`mr_t[n]`, `mr_f[n]`): (1,0) means 1, (0,1) means 0, (0,0) means not yet valid. While `req` is high and any pair is (0,0), no evaluation starts. Capture happens on the first clock edge with `req` high and every pair valid.
- R4: If any pair is (1,1) at a clock edge with `req` high in the idle state, `err` is high after that edge and `done` stays low. `err` falls on the first edge with `req` low.
- R5: Counting the capture edge as edge 0, `done` rises at edge k+1, where k is the number of ones in the multiplier magnitude. A zero bit adds no cycle.
- R6: While `done` and `req` are both high, `done`, `p_mag` and `p_sign` hold their values even if the operand inputs change.
- R7: On the first clock edge with `req` low while `done` is high, `done` falls and `p_mag` and `p_sign` return to 0.
- R8: During reset `done`, `err`, `p_mag` and `p_sign` are 0. After reset `req` is taken as previously low, so a `req` that is already high when reset is released starts an evaluation on the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Four-phase request |
| a_sign | input | 1 | Multiplicand sign (1 = negative) |
| a_mag | input | MAG_W | Multiplicand magnitude |
| b_sign | input | 1 | Multiplier sign (1 = negative) |
| mr_t | input | MAG_W | Multiplier magnitude, true rails |
| mr_f | input | MAG_W | Multiplier magnitude, false rails |
| done | output | 1 | Result valid / completion |
| err | output | 1 | Illegal dual-rail code seen |
| p_sign | output | 1 | Product sign |
| p_mag | output | 2*MAG_W | Product magnitude |

## Verification
A fault in the row gating or the pending-row mask shows up at the ports in two ways. `done` rises on the wrong edge, and `p_mag` is wrong at that same edge, because a skipped or repeated row loses or doubles a shifted partial product. A corrupted carry-save pair shows up only at the final add, so it is visible on the first cycle that `done` is high and not before. Faults in clearing or in the dual-rail register show up one edge after `req` falls: `p_mag` fails to return to zero, or the next operation starts from stale rails or raises `err` when it should not.

// File: rtl/dd_smul_pkg.sv
// Package: shared state encoding for the data-dependent multiplier.
// Assumes: included ahead of every module of the block.
package dd_smul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // waiting for a valid request
        ST_ROWS  = 3'd1,   // applying enabled adder rows, one per cycle
        ST_CPA   = 3'd2,   // final carry-propagate addition
        ST_HOLD  = 3'd3,   // result presented, waiting for req to fall
        ST_FAULT = 3'd4    // illegal rail code seen, waiting for req to fall
    } smul_state_t;

endpackage

// File: rtl/dd_smul_rail_dec.sv
// Module: dual-rail decoder for the multiplier magnitude.
// Does: turns each (t,f) pair into a value bit, and reports whether
//       every pair holds a code (complete) and whether any pair is (1,1).
// Assumes: purely combinational; the caller decides when to sample.
module dd_smul_rail_dec #(
    parameter int W = 4
) (
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic [W-1:0] val,
    output logic         complete,
    output logic         illegal
);

    logic [W-1:0] pair_ok;
    logic [W-1:0] pair_bad;

    // One decoder cell per rail pair.
    for (genvar i = 0; i < W; i++) begin : g_pair
        assign val[i]      = rail_t[i];
        assign pair_ok[i]  = rail_t[i] ^ rail_f[i];
        assign pair_bad[i] = rail_t[i] & rail_f[i];
    end

    // Completion and fault summary over all pairs.
    always_comb begin
        complete = &pair_ok;
        illegal  = |pair_bad;
    end

endmodule

// File: rtl/dd_smul_csa_row.sv
// Module: one gated carry-save adder row of the magnitude array.
// Does: when en is high, adds the multiplicand shifted by ROW into the
//       (sum, carry) pair; when en is low, the pair passes through unchanged.
// Assumes: the final product fits PROD_W bits, so the top carry is dropped.
module dd_smul_csa_row #(
    parameter int MAG_W  = 4,
    parameter int PROD_W = 8,
    parameter int ROW    = 0
) (
    input  logic              en,
    input  logic [MAG_W-1:0]  mcand,
    input  logic [PROD_W-1:0] sum_i,
    input  logic [PROD_W-1:0] carry_i,
    output logic [PROD_W-1:0] sum_o,
    output logic [PROD_W-1:0] carry_o
);

    logic [PROD_W-1:0] pp;
    logic [PROD_W-1:0] fa_sum;
    logic [PROD_W-1:0] fa_maj;

    // Partial product for this row: shifted multiplicand.
    always_comb pp = PROD_W'(mcand) << ROW;

    // Full adder cells, one per product bit.
    for (genvar i = 0; i < PROD_W; i++) begin : g_cell
        assign fa_sum[i] = sum_i[i] ^ carry_i[i] ^ pp[i];
        assign fa_maj[i] = (sum_i[i] & carry_i[i]) | (sum_i[i] & pp[i]) |
                           (carry_i[i] & pp[i]);
    end

    // Bypass mux: disabled row forwards its inputs.
    always_comb begin
        if (en) begin
            sum_o   = fa_sum;
            carry_o = {fa_maj[PROD_W-2:0], 1'b0};
        end else begin
            sum_o   = sum_i;
            carry_o = carry_i;
        end
    end

endmodule

// File: rtl/dd_smul_cpa.sv
// Module: final carry-propagate adder merging the carry-save pair.
// Does: ripple addition of sum and carry vectors, result modulo 2^W.
// Assumes: combinational; result is registered by the caller.
module dd_smul_cpa #(
    parameter int W = 8
) (
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] res
);

    logic [W:0] c;

    // Carry into bit 0 is zero.
    assign c[0] = 1'b0;

    // Ripple chain, one cell per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign res[i]   = sum_i[i] ^ carry_i[i] ^ c[i];
        assign c[i+1]   = (sum_i[i] & carry_i[i]) | (c[i] & (sum_i[i] ^ carry_i[i]));
    end

endmodule

// File: rtl/dd_smul_ctrl.sv
// Module: four-phase handshake controller for the multiplier.
// Does: sequences idle -> rows -> final add -> hold -> idle, or
//       idle -> fault -> idle, and emits one-cycle strobes to the datapath.
// Assumes: req is synchronous to clk; reset puts the controller in idle,
//          which treats req as having been low.
module dd_smul_ctrl
    import dd_smul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic complete,
    input  logic illegal,
    input  logic zero_mr,
    input  logic last_row,
    output logic load,
    output logic step,
    output logic finish,
    output logic clear,
    output logic done,
    output logic err
);

    smul_state_t st_q;
    smul_state_t st_d;

    // Strobes decoded from the present state and inputs.
    always_comb begin
        load   = (st_q == ST_IDLE) && req && !illegal && complete;
        step   = (st_q == ST_ROWS);
        finish = (st_q == ST_CPA);
        clear  = ((st_q == ST_HOLD) || (st_q == ST_FAULT)) && !req;
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req && illegal)   st_d = ST_FAULT;
                else if (load)        st_d = zero_mr ? ST_CPA : ST_ROWS;
            end
            ST_ROWS:  if (last_row) st_d = ST_CPA;
            ST_CPA:   st_d = ST_HOLD;
            ST_HOLD:  if (!req) st_d = ST_IDLE;
            ST_FAULT: if (!req) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Registered handshake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= (st_d == ST_HOLD);
            err  <= (st_d == ST_FAULT);
        end
    end

endmodule

// File: rtl/dd_smul.sv
// Module: data-dependent sign-magnitude multiplier (top).
// Does: captures operands on a valid request, runs one gated carry-save
//       row per one-bit of the multiplier magnitude, merges with a final
//       add, and presents sign and magnitude until req falls.
// Assumes: operands are stable from req rising until done rises; the
//          multiplier magnitude is dual-rail coded.
module dd_smul #(
    parameter int MAG_W = 4,
    localparam int PROD_W = 2 * MAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              a_sign,
    input  logic [MAG_W-1:0]  a_mag,
    input  logic              b_sign,
    input  logic [MAG_W-1:0]  mr_t,
    input  logic [MAG_W-1:0]  mr_f,
    output logic              done,
    output logic              err,
    output logic              p_sign,
    output logic [PROD_W-1:0] p_mag
);

    logic [MAG_W-1:0]  dec_val;
    logic              dec_complete;
    logic              dec_illegal;
    logic              load;
    logic              step;
    logic              finish;
    logic              clear;

    logic [MAG_W-1:0]  a_mag_q;
    logic              a_sign_q;
    logic              b_sign_q;
    logic [MAG_W-1:0]  mr_t_q;
    logic [MAG_W-1:0]  mr_f_q;
    logic [MAG_W-1:0]  mask_q;
    logic [MAG_W-1:0]  sel;
    logic [MAG_W-1:0]  row_en;
    logic [PROD_W-1:0] sum_q;
    logic [PROD_W-1:0] carry_q;
    logic [PROD_W-1:0] cpa_out;
    logic [PROD_W-1:0] p_mag_q;
    logic              p_sign_q;

    logic [PROD_W-1:0] s_ch [MAG_W+1];
    logic [PROD_W-1:0] c_ch [MAG_W+1];

    // Decode the incoming dual-rail multiplier.
    dd_smul_rail_dec #(.W(MAG_W)) dec_i (
        .rail_t   (mr_t),
        .rail_f   (mr_f),
        .val      (dec_val),
        .complete (dec_complete),
        .illegal  (dec_illegal)
    );

    // Lowest pending row, and gate enables from the held rails.
    always_comb begin
        sel    = mask_q & (~mask_q + MAG_W'(1));
        row_en = sel & mr_t_q & ~mr_f_q & {MAG_W{step}};
    end

    // Handshake controller.
    dd_smul_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .complete (dec_complete),
        .illegal  (dec_illegal),
        .zero_mr  (dec_val == '0),
        .last_row ((mask_q & ~sel) == '0),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .clear    (clear),
        .done     (done),
        .err      (err)
    );

    // Head of the row chain is the held carry-save pair.
    assign s_ch[0] = sum_q;
    assign c_ch[0] = carry_q;

    // Array of gated rows; at most one is enabled per cycle.
    for (genvar n = 0; n < MAG_W; n++) begin : g_row
        dd_smul_csa_row #(
            .MAG_W  (MAG_W),
            .PROD_W (PROD_W),
            .ROW    (n)
        ) row_i (
            .en      (row_en[n]),
            .mcand   (a_mag_q),
            .sum_i   (s_ch[n]),
            .carry_i (c_ch[n]),
            .sum_o   (s_ch[n+1]),
            .carry_o (c_ch[n+1])
        );
    end

    // Final merge of the carry-save pair.
    dd_smul_cpa #(.W(PROD_W)) cpa_i (
        .sum_i   (sum_q),
        .carry_i (carry_q),
        .res     (cpa_out)
    );

    // Operand capture and return-to-zero of the operand/rail registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            a_mag_q  <= '0;
            a_sign_q <= 1'b0;
            b_sign_q <= 1'b0;
            mr_t_q   <= '0;
            mr_f_q   <= '0;
        end else if (load) begin
            a_mag_q  <= a_mag;
            a_sign_q <= a_sign;
            b_sign_q <= b_sign;
            mr_t_q   <= mr_t;
            mr_f_q   <= mr_f;
        end
    end

    // Carry-save accumulation and pending-row mask.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mask_q  <= '0;
            sum_q   <= '0;
            carry_q <= '0;
        end else if (load) begin
            mask_q  <= dec_val;
            sum_q   <= '0;
            carry_q <= '0;
        end else if (step) begin
            mask_q  <= mask_q & ~sel;
            sum_q   <= s_ch[MAG_W];
            carry_q <= c_ch[MAG_W];
        end
    end

    // Product register, written by the final add and cleared on return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            p_mag_q  <= '0;
            p_sign_q <= 1'b0;
        end else if (finish) begin
            p_mag_q  <= cpa_out;
            p_sign_q <= (|cpa_out) & (a_sign_q ^ b_sign_q);
        end
    end

    assign p_mag  = p_mag_q;
    assign p_sign = p_sign_q;

endmodule

// File: rtl/dd_smul_chk.sv
// Module: property checker for dd_smul, attached by bind.
// Does: watches handshake ports and the held operand registers.
// Assumes: clk and rst_n are those of the checked instance.
module dd_smul_chk #(
    parameter int MAG_W = 4,
    localparam int PROD_W = 2 * MAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              done,
    input logic              err,
    input logic              p_sign,
    input logic [PROD_W-1:0] p_mag,
    input logic [MAG_W-1:0]  a_mag_q,
    input logic [MAG_W-1:0]  mr_t_q,
    input logic [MAG_W-1:0]  mr_f_q
);

    // R1
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> p_mag == (PROD_W'(a_mag_q) * PROD_W'(mr_t_q)));

    // R2
    zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && p_mag == '0) |-> !p_sign);

    // R3
    rail_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_t_q & mr_f_q) == '0);

    // R4
    err_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && done));

    // R4
    err_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && req) |=> err);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req) |=> (done && $stable(p_mag) && $stable(p_sign)));

    // R7
    rtz_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req) |=> (!done && p_mag == '0 && !p_sign));

endmodule

bind dd_smul dd_smul_chk #(.MAG_W(MAG_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .done    (done),
    .err     (err),
    .p_sign  (p_sign),
    .p_mag   (p_mag),
    .a_mag_q (a_mag_q),
    .mr_t_q  (mr_t_q),
    .mr_f_q  (mr_f_q)
);

// File: tb/dd_smul_tb_top.sv
module dd_smul_tb_top;

    typedef struct packed {
        logic       as;
        logic [3:0] am;
        logic       bs;
        logic [3:0] bm;
        logic       es;
        logic [7:0] em;
        logic [3:0] edges;   // negedges from req raise to done seen: popcount(bm)+2
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 4'd3,  1'b0, 4'd5,  1'b0, 8'd15,  4'd4},
        '{1'b1, 4'd7,  1'b0, 4'd6,  1'b1, 8'd42,  4'd4},
        '{1'b0, 4'd15, 1'b1, 4'd15, 1'b1, 8'd225, 4'd6},
        '{1'b1, 4'd9,  1'b1, 4'd0,  1'b0, 8'd0,   4'd2},
        '{1'b1, 4'd0,  1'b0, 4'd8,  1'b0, 8'd0,   4'd3},
        '{1'b0, 4'd1,  1'b1, 4'd1,  1'b1, 8'd1,   4'd3},
        '{1'b1, 4'd12, 1'b1, 4'd10, 1'b0, 8'd120, 4'd4},
        '{1'b0, 4'd5,  1'b0, 4'd7,  1'b0, 8'd35,  4'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       a_sign = 1'b0;
    logic [3:0] a_mag = '0;
    logic       b_sign = 1'b0;
    logic [3:0] mr_t = '0;
    logic [3:0] mr_f = '0;
    logic       done;
    logic       err;
    logic       p_sign;
    logic [7:0] p_mag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dd_smul #(.MAG_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign),
        .mr_t(mr_t), .mr_f(mr_f),
        .done(done), .err(err), .p_sign(p_sign), .p_mag(p_mag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input logic as, input logic [3:0] am,
                         input logic bs, input logic [3:0] bm);
        a_sign = as; a_mag = am; b_sign = bs;
        mr_t = bm; mr_f = ~bm;
    endtask

    // Count negedges until done is seen (limit 40).
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 40);
    endtask

    // Full transaction from a negedge with req low; checks R1 R2 R5 R6 R7.
    task automatic txn(input vec_t v, input string id);
        int n;
        drive(v.as, v.am, v.bs, v.bm);
        req = 1'b1;
        wait_done(n);
        chk({"R5 latency ", id}, n, int'(v.edges));
        chk({"R1 magnitude ", id}, int'(p_mag), int'(v.em));
        chk({"R2 sign ", id}, int'(p_sign), int'(v.es));
        drive(~v.as, ~v.am, ~v.bs, ~v.bm);
        @(negedge clk);
        @(negedge clk);
        chk({"R6 hold done ", id}, int'(done), 1);
        chk({"R6 hold mag ", id}, int'(p_mag), int'(v.em));
        req = 1'b0;
        @(negedge clk);
        chk({"R7 done low ", id}, int'(done), 0);
        chk({"R7 mag zero ", id}, int'(p_mag), 0);
        @(negedge clk);
    endtask

    initial begin
        int n;
        // R8 reset state with req low
        repeat (3) @(negedge clk);
        chk("R8 reset done", int'(done), 0);
        chk("R8 reset err", int'(err), 0);
        chk("R8 reset mag", int'(p_mag), 0);
        chk("R8 reset sign", int'(p_sign), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            txn(VEC[i], $sformatf("vec%0d", i));
        end

        // R3 incomplete rails: (0,0) on bit 2 delays capture
        drive(1'b0, 4'd6, 1'b1, 4'd5);
        mr_t = 4'b0001; mr_f = 4'b1010;
        req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 wait no done", int'(done), 0);
        chk("R3 wait no err", int'(err), 0);
        mr_t = 4'd5; mr_f = ~4'd5;
        wait_done(n);
        chk("R3 latency after rails valid", n, 4);
        chk("R3 product after wait", int'(p_mag), 30);
        chk("R3 sign after wait", int'(p_sign), 1);
        req = 1'b0;
        repeat (2) @(negedge clk);

        // R4 illegal (1,1) pair
        drive(1'b0, 4'd3, 1'b0, 4'd3);
        mr_f[1] = 1'b1;
        req = 1'b1;
        @(negedge clk);
        chk("R4 err raised", int'(err), 1);
        chk("R4 no done", int'(done), 0);
        mr_t = 4'd3; mr_f = ~4'd3;
        repeat (3) @(negedge clk);
        chk("R4 err held, no start", int'(err), 1);
        chk("R4 still no done", int'(done), 0);
        chk("R4 mag untouched", int'(p_mag), 0);
        req = 1'b0;
        @(negedge clk);
        chk("R4 err cleared", int'(err), 0);
        @(negedge clk);
        txn('{1'b1, 4'd3, 1'b0, 4'd3, 1'b1, 8'd9, 4'd4}, "after fault");

        // R8 req already high while reset is released
        rst_n = 1'b0;
        drive(1'b1, 4'd11, 1'b1, 4'd13);
        req = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 reset with req high done", int'(done), 0);
        rst_n = 1'b1;
        wait_done(n);
        chk("R8 start after reset latency", n, 5);
        chk("R8 start after reset product", int'(p_mag), 143);
        chk("R8 start after reset sign", int'(p_sign), 0);
        req = 1'b0;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule